// File: doc/BRIEF.md
# Zero-Page Window Dual-Port Access Sequencer

This block sits between a coprocessor and its memory bus. It takes memory cycles that fall in the lowest 256-byte page and sends them to an external dual-port RAM whose port shares its address and data lines. The redirection only happens while a window bit is set. Software sets or clears that bit with an I/O write, and the bit comes out of reset cleared.

For a redirected cycle, the block blocks the memory request to the system RAM. It then runs a fixed five-step sequence on the shared port. First an address phase with chip enable, then a data phase in which the write or output strobe follows the coprocessor's write or read line. The coprocessor's wait line is held asserted through four clocks, so each half of the port access lasts two bus clocks. After the sequence the machine releases every strobe and the wait line. It then stays in a hold state, so a cycle that is still in progress cannot start it again. It returns to idle only when the redirected request ends.

All outputs are active low. They are combinational on the current request and the registered sequencer state, so the strobes drop in the same cycle as the request.

Top module: `zp_window_seq`

## Requirements
- R1: A cycle is a window cycle only when cpu_addr[15:8] is all zero. A memory request at 0x0100 or 0xFF00 passes to sys_mreq_n and drives no strobe, even with the window enabled.
- R2: An I/O write (cpu_iorq_n=0, cpu_wr_n=0) with cpu_addr[7]=1 loads the window bit from cpu_data[0] at the clock edge. The new value governs requests from the next cycle on.
- R3: An I/O read, or an I/O write with cpu_addr[7]=0, leaves the window bit unchanged.
- R4: After reset the window bit is 0, so zero-page requests pass to sys_mreq_n and no strobe or wait is driven.
- R5: While a window cycle is requested (cpu_mreq_n=0, zero page, window set), sys_mreq_n is 1. Otherwise sys_mreq_n equals cpu_mreq_n.
- R6: In the two cycles after the first edge that sees a window request, dp_ce_n, dp_aphase_n and cpu_wait_n are 0, and dp_we_n and dp_oe_n are 1.
- R7: In the following two cycles, dp_ce_n and cpu_wait_n stay 0, dp_aphase_n is 1, dp_we_n equals cpu_wr_n and dp_oe_n equals cpu_rd_n.
- R8: After those four wait cycles, all strobes and cpu_wait_n go to 1 while the request is held, and the sequence does not restart for as long as it stays held.
- R9: Whenever no window request is present, dp_ce_n, dp_aphase_n, dp_we_n, dp_oe_n and cpu_wait_n are all 1, including a request that ends partway through the sequence.
- R10: Once the request has been inactive for at least one clock edge, a new window request runs the full sequence again from its first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | Coprocessor address bus |
| cpu_data | input | 8 | Coprocessor data bus (bit 0 sampled on window writes) |
| cpu_mreq_n | input | 1 | Coprocessor memory request, active low |
| cpu_iorq_n | input | 1 | Coprocessor I/O request, active low |
| cpu_rd_n | input | 1 | Coprocessor read strobe, active low |
| cpu_wr_n | input | 1 | Coprocessor write strobe, active low |
| sys_mreq_n | output | 1 | Memory request passed to system RAM, active low |
| dp_ce_n | output | 1 | Dual-port chip enable, active low |
| dp_aphase_n | output | 1 | Address-phase driver enable, active low |
| dp_we_n | output | 1 | Dual-port write enable, active low |
| dp_oe_n | output | 1 | Dual-port output enable, active low |
| cpu_wait_n | output | 1 | Wait request to the coprocessor, active low |

## Verification
Each error in the sequencer state shows at the ports within one cycle. A skipped or repeated step changes how long cpu_wait_n stays low, or moves the edge where dp_aphase_n hands over to dp_we_n or dp_oe_n. A hold state that fails to latch appears as a second fall of dp_ce_n while the same request is still active. A window bit that is wrong shows on the next zero-page request: sys_mreq_n either passes when it should be blocked, or is blocked when it should pass. The bench runs a behavioural model alongside the design and compares all six outputs every cycle, so any such divergence is reported in the cycle where it first appears.

// File: rtl/zpw_pkg.sv
`timescale 1ns/1ps
// Shared types for the zero-page window sequencer.
package zpw_pkg;
    // Sequencer steps, in the order a window access walks through them.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_HOLD_A = 3'd2,
        ST_XFER   = 3'd3,
        ST_HOLD_D = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/zpw_page_detect.sv
`timescale 1ns/1ps
// Page detector. It flags an address whose upper bits select the window page.
// Assumes: the address is stable for the whole cycle; the detector is purely combinational.
module zpw_page_detect #(
    parameter int ADDR_W      = 16,
    parameter int OFFS_W      = 8,
    parameter int WINDOW_PAGE = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_page
);
    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam logic [PAGE_W-1:0] PAGE_ID = WINDOW_PAGE[PAGE_W-1:0];

    // Compare the page-number field with the selected page.
    always_comb begin
        in_page = (addr[ADDR_W-1:OFFS_W] == PAGE_ID);
    end
endmodule

// File: rtl/zpw_window_reg.sv
`timescale 1ns/1ps
// Window-enable register. An I/O write with the select address bit set loads it
// from the control data bit.
// Assumes: an I/O write holds its strobes for at least one clock edge; reset is synchronous.
module zpw_window_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic io_req_n,
    input  logic io_wr_n,
    input  logic sel_bit,
    input  logic ctrl_bit,
    output logic win_en
);
    logic load;

    // Decode a window-control write.
    always_comb begin
        load = !io_req_n && !io_wr_n && sel_bit;
    end

    // Hold the window bit; it is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_en <= 1'b0;
        else if (load)   win_en <= ctrl_bit;
    end

    // R2: a control write lands in the bit on the next cycle
    a_r2_window_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_req_n && !io_wr_n && sel_bit) |=> (win_en == $past(ctrl_bit)));

    // R3: any other cycle leaves the bit alone
    a_r3_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(!io_req_n && !io_wr_n && sel_bit) |=> $stable(win_en));
endmodule

// File: rtl/zpw_seq_fsm.sv
`timescale 1ns/1ps
// Access sequencer for the multiplexed dual-port RAM port. It steps through an
// address phase, a data phase and a hold state. Its strobes are gated by the
// live request.
// Assumes: the request stays active while wait is asserted; strobes are active high here.
module zpw_seq_fsm
    import zpw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic rd_n,
    input  logic wr_n,
    output logic ce,
    output logic aphase,
    output logic we,
    output logic oe,
    output logic wait_o,
    output logic stretch
);
    seq_state_t state, state_nx;

    // Choose the next step; any gap in the request returns to idle.
    always_comb begin
        state_nx = state;
        if (!req) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_START;
                ST_START:  state_nx = ST_HOLD_A;
                ST_HOLD_A: state_nx = ST_XFER;
                ST_XFER:   state_nx = ST_HOLD_D;
                ST_HOLD_D: state_nx = ST_DONE;
                ST_DONE:   state_nx = ST_DONE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Register the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Decode the strobes of each step, gated by the live request.
    always_comb begin
        ce     = 1'b0;
        aphase = 1'b0;
        we     = 1'b0;
        oe     = 1'b0;
        wait_o = 1'b0;
        if (req) begin
            unique case (state)
                ST_START, ST_HOLD_A: begin
                    ce     = 1'b1;
                    aphase = 1'b1;
                    wait_o = 1'b1;
                end
                ST_XFER, ST_HOLD_D: begin
                    ce     = 1'b1;
                    wait_o = 1'b1;
                    we     = !wr_n;
                    oe     = !rd_n;
                end
                default: ;
            endcase
        end
    end

    // Stretch flag: the sequence is in progress or being held off.
    always_comb begin
        stretch = (state != ST_IDLE);
    end

    // R8: a held request keeps the machine parked in the hold state
    a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && req) |=> (state == ST_DONE && stretch));

    // R10: a dropped request always brings the machine back to idle
    a_r10_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (state == ST_IDLE));
endmodule

// File: rtl/zp_window_seq.sv
`timescale 1ns/1ps
// Zero-page window sequencer top. It routes zero-page memory cycles to a
// multiplexed dual-port RAM while the window is enabled, blocks the system
// memory request for them and stretches them with coprocessor wait states.
// Assumes: all bus strobes are active low and synchronous to clk; reset is synchronous.
module zp_window_seq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int OFFS_W      = 8,
    parameter int WINDOW_PAGE = 0,
    parameter int SEL_BIT     = 7,
    parameter int CTRL_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_mreq_n,
    input  logic              cpu_iorq_n,
    input  logic              cpu_rd_n,
    input  logic              cpu_wr_n,
    output logic              sys_mreq_n,
    output logic              dp_ce_n,
    output logic              dp_aphase_n,
    output logic              dp_we_n,
    output logic              dp_oe_n,
    output logic              cpu_wait_n
);
    localparam int WAIT_LEN = 4;
    localparam int RUN_W    = $clog2(WAIT_LEN + 2);

    logic in_page, win_en, win_req;
    logic ce, aphase, we, oe, wait_o, stretch;
    logic unused_bus;

    // Bus bits the control decode does not look at.
    always_comb begin
        unused_bus = ^{cpu_addr, cpu_data, stretch};
    end

    zpw_page_detect #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WINDOW_PAGE(WINDOW_PAGE)
    ) u_page (
        .addr    (cpu_addr),
        .in_page (in_page)
    );

    zpw_window_reg u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_req_n (cpu_iorq_n),
        .io_wr_n  (cpu_wr_n),
        .sel_bit  (cpu_addr[SEL_BIT]),
        .ctrl_bit (cpu_data[CTRL_BIT]),
        .win_en   (win_en)
    );

    // A memory cycle that the window takes over.
    always_comb begin
        win_req = !cpu_mreq_n && in_page && win_en;
    end

    zpw_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (win_req),
        .rd_n    (cpu_rd_n),
        .wr_n    (cpu_wr_n),
        .ce      (ce),
        .aphase  (aphase),
        .we      (we),
        .oe      (oe),
        .wait_o  (wait_o),
        .stretch (stretch)
    );

    // Drive the active-low pins and block the system request for window cycles.
    always_comb begin
        sys_mreq_n  = cpu_mreq_n || win_req;
        dp_ce_n     = !ce;
        dp_aphase_n = !aphase;
        dp_we_n     = !we;
        dp_oe_n     = !oe;
        cpu_wait_n  = !wait_o;
    end

    // Checker counter: length of the current run of wait cycles.
    logic [RUN_W-1:0] wait_run;
    always_ff @(posedge clk) begin
        if (!rst_n)           wait_run <= '0;
        else if (!cpu_wait_n) wait_run <= (wait_run == RUN_W'(WAIT_LEN + 1)) ? wait_run : wait_run + 1'b1;
        else                  wait_run <= '0;
    end

    // R8: wait is never held for more than four clocks in a row
    a_r8_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wait_run <= RUN_W'(WAIT_LEN));

    // R6: chip enable opens with the address phase and no data strobe
    a_r6_address_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dp_ce_n) |-> (!dp_aphase_n && dp_we_n && dp_oe_n && !cpu_wait_n));

    // R7: data strobes only appear after the address phase, under chip enable
    a_r7_strobe_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_we_n || !dp_oe_n) |-> (dp_aphase_n && !dp_ce_n));

    // R5: a port strobe never coexists with a passed-on system request
    a_r5_exclusive_target: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_ce_n |-> sys_mreq_n);
endmodule

// File: tb/sim_zp_window_seq.sv
`timescale 1ns/1ps
module sim_zp_window_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data = 8'h00;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        sys_mreq_n, dp_ce_n, dp_aphase_n, dp_we_n, dp_oe_n, cpu_wait_n;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    finished = 1'b0;
    string tag = "R4 reset";

    // Behavioural reference: window bit and position in the access sequence.
    int m_win   = 0;
    int m_phase = 0;   // 0 idle, 1..4 wait steps, 5 held off

    always #2.5 clk = ~clk;

    zp_window_seq u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_data(data),
        .cpu_mreq_n(mreq_n), .cpu_iorq_n(iorq_n), .cpu_rd_n(rd_n), .cpu_wr_n(wr_n),
        .sys_mreq_n(sys_mreq_n), .dp_ce_n(dp_ce_n), .dp_aphase_n(dp_aphase_n),
        .dp_we_n(dp_we_n), .dp_oe_n(dp_oe_n), .cpu_wait_n(cpu_wait_n)
    );

    function automatic bit model_req();
        return (mreq_n == 1'b0) && (addr[15:8] == 8'h00) && (m_win != 0);
    endfunction

    // Reference model update at each edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_win = 0;
            m_phase = 0;
        end else begin
            bit r;
            r = model_req();
            if (!r)                m_phase = 0;
            else if (m_phase < 5)  m_phase = m_phase + 1;
            if (!iorq_n && !wr_n && addr[7]) m_win = data[0];
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Compare every output against the model, away from the edge.
    always @(negedge clk) begin
        if (!finished) begin
            bit r, act, adr, dat;
            r   = model_req();
            act = r && (m_phase >= 1) && (m_phase <= 4);
            adr = r && (m_phase >= 1) && (m_phase <= 2);
            dat = r && (m_phase >= 3) && (m_phase <= 4);
            chk("sys_mreq_n",  sys_mreq_n,  mreq_n | r);
            chk("dp_ce_n",     dp_ce_n,     !act);
            chk("cpu_wait_n",  cpu_wait_n,  !act);
            chk("dp_aphase_n", dp_aphase_n, !adr);
            chk("dp_we_n",     dp_we_n,     !(dat && !wr_n));
            chk("dp_oe_n",     dp_oe_n,     !(dat && !rd_n));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected below 20000", cycles);
            summary();
        end
    end

    task automatic step(input logic [15:0] a, input logic [7:0] d,
                        input logic m, input logic io, input logic r, input logic w,
                        input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            addr = a; data = d; mreq_n = m; iorq_n = io; rd_n = r; wr_n = w;
        end
    endtask

    task automatic idle(input int n);
        step(16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, n);
    endtask

    initial begin
        idle(3);
        @(posedge clk); #1; rst_n = 1'b1;
        tag = "R4 window off after reset";
        step(16'h0010, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4);
        idle(1);
        tag = "R2 enable write";
        step(16'h0080, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        idle(1);
        tag = "R6 R7 R8 zero-page read sequence";
        step(16'h0020, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8);
        tag = "R10 restart after gap, write";
        idle(1);
        step(16'h0042, 8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 7);
        idle(2);
        tag = "R3 io read and unselected io write";
        step(16'h00FF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 2);
        step(16'h007F, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 2);
        idle(1);
        tag = "R3 window still on";
        step(16'h00FF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 6);
        idle(1);
        tag = "R1 page 0x01 and 0xFF not in window";
        step(16'h0100, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 5);
        step(16'hFF00, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 5);
        idle(1);
        tag = "R9 request drops mid sequence";
        step(16'h0001, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 2);
        idle(1);
        step(16'h0002, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 3);
        idle(2);
        tag = "R8 long hold no retrigger";
        step(16'h0003, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 12);
        idle(1);
        tag = "R2 disable write";
        step(16'h00C0, 8'hFE, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        tag = "R5 zero page passes when window off";
        step(16'h0004, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 4);
        idle(1);
        tag = "R2 enable again then R5 blocked";
        step(16'h0081, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0, 1);
        step(16'h0005, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 6);
        idle(3);
        finished = 1'b1;
        summary();
    end
endmodule